// File: doc/BRIEF.md
# DMA Address Update Unit with Wrap Region

This block produces the next source or destination address of a DMA channel after each data beat. A sequencer drives a beat strobe and a reload strobe. The unit combines those strobes with the current address, a reload address, a 32-bit offset, the beat size and an update-mode code, and registers the result. One instance serves one direction, so a channel uses two of them.

A 4-bit wrap-area field can confine the low address bits to a power-of-two window. When that window is active, the unit updates the low bits modulo the window size and leaves the high bits alone. Each time the low bits roll over or under, it raises an interrupt-request pulse, but only if the overflow enable is set.

On a reload, the address comes from the reload input. A select bit decides whether that value is used directly or has one normal update applied to it in the same cycle.

Top module: `dma_addr_upd`

## Requirements
- R1: During reset and in the first cycle after it, `next_addr_o` is 0 and `ovf_irq_o` is 0.
- R2: Mode code 00 (fixed): a beat makes `next_addr_o` equal to `cur_addr_i`. A fixed-mode update never raises `ovf_irq_o`.
- R3: Mode code 10 (increment): a beat adds a step to `cur_addr_i`. The step is 1, 2 or 4 for size codes 00, 01 and 10. Size code 11 is prohibited and gives a step of 0.
- R4: Mode code 11 (decrement): a beat subtracts the same size-dependent step from `cur_addr_i`.
- R5: Mode code 01 (offset): a beat adds `offset_i` to `cur_addr_i`, modulo 2^32.
- R6: When `reload_i` is high and `reload_idx_i` is 0, `next_addr_o` becomes `reload_addr_i`, whatever the state of `beat_i`. No overflow is raised.
- R7: When `reload_i` is high and `reload_idx_i` is 1, `next_addr_o` becomes `reload_addr_i` with one update of the current mode applied.
- R8: A nonzero `area_i` value n keeps address bits above bit n-1. The low n bits are updated modulo 2^n, and the step or offset used for them is reduced modulo 2^n first. A value of 0 wraps the full address modulo 2^32.
- R9: An update that carries out of the low n bits, or borrows into them (n nonzero), raises `ovf_irq_o` for exactly the next cycle, provided `ovf_en_i` is 1. With `ovf_en_i` at 0, `ovf_irq_o` stays low.
- R10: In a cycle with neither `beat_i` nor `reload_i`, `next_addr_o` holds its value and `ovf_irq_o` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| beat_i | input | 1 | One beat completed: update the address |
| reload_i | input | 1 | Reload the address (takes priority over beat) |
| cur_addr_i | input | 32 | Current address |
| reload_addr_i | input | 32 | Reload address |
| offset_i | input | 32 | Addend for offset mode |
| size_i | input | 2 | Beat size code: 00 byte, 01 half, 10 word |
| mode_i | input | 2 | Update mode: 00 fixed, 01 offset, 10 inc, 11 dec |
| reload_idx_i | input | 1 | 1: apply one update after reload |
| area_i | input | 4 | Wrap-area width n (0 = no wrap) |
| ovf_en_i | input | 1 | Overflow interrupt enable |
| next_addr_o | output | 32 | Registered updated address |
| ovf_irq_o | output | 1 | One-cycle overflow interrupt request |

## Verification
The bench sweeps every mode code against every size code, including the prohibited one. Each combination is run at wrap widths 0, 1, 2, 3, 4, 8 and 15, from base addresses that sit at the bottom, the middle and the top of a window and at the top of the full address range. This mix separates plain full-width carry from windowed wrap, and it shows whether a rollover comes out as carry or as borrow, and at which size. Every such case runs with the enable both on and off, which shows the gating. Reload runs then compare plain reload against reload with indexing while a beat is driven in the same cycle. Idle cycles after each operation show that the address holds and no stray pulse appears.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

  typedef enum logic [1:0] {
    UPD_FIXED  = 2'b00,
    UPD_OFFSET = 2'b01,
    UPD_INC    = 2'b10,
    UPD_DEC    = 2'b11
  } upd_mode_e;

  // Byte step for a beat size code; the prohibited code yields 0.
  function automatic logic [2:0] step_bytes(input logic [1:0] size);
    case (size)
      2'b00:   step_bytes = 3'd1;
      2'b01:   step_bytes = 3'd2;
      2'b10:   step_bytes = 3'd4;
      default: step_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_addr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [1:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] offset_i,
  output logic [AW-1:0] addend_o,
  output logic          sub_o
);

  logic [2:0] step_w;
  assign step_w = step_bytes(size_i);

  always_comb begin
    addend_o = '0;
    sub_o    = 1'b0;
    case (upd_mode_e'(mode_i))
      UPD_OFFSET: addend_o = offset_i;
      UPD_INC:    addend_o = AW'(step_w);
      UPD_DEC: begin
        addend_o = AW'(step_w);
        sub_o    = 1'b1;
      end
      default:    addend_o = '0;
    endcase
  end

endmodule

// File: rtl/dma_addr_wrap.sv
module dma_addr_wrap #(
  parameter int AW     = 32,
  parameter int AREA_W = 4
) (
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     addend_i,
  input  logic              sub_i,
  input  logic [AREA_W-1:0] area_i,
  output logic [AW-1:0]     result_o,
  output logic              wrap_o
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic          area_on;
  logic [AW-1:0] mask;
  logic [AW-1:0] raw;
  logic [AW-1:0] low_base;
  logic [AW-1:0] low_add;
  logic [AW:0]   low_sum;

  assign area_on  = (area_i != '0);
  assign mask     = area_on ? ((ONE << area_i) - ONE) : '0;
  assign raw      = sub_i ? (base_i - addend_i) : (base_i + addend_i);
  assign low_base = base_i & mask;
  assign low_add  = addend_i & mask;
  assign low_sum  = {1'b0, low_base} + {1'b0, low_add};

  // Window merge: upper bits from base, lower bits from the raw sum.
  assign result_o = area_on ? ((base_i & ~mask) | (raw & mask)) : raw;

  always_comb begin
    if (!area_on)   wrap_o = 1'b0;
    else if (sub_i) wrap_o = (low_base < low_add);
    else            wrap_o = (low_sum > {1'b0, mask});
  end

endmodule

// File: rtl/dma_addr_upd.sv
module dma_addr_upd
  import dma_addr_pkg::*;
#(
  parameter int AW     = 32,
  parameter int AREA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_i,
  input  logic              reload_i,
  input  logic [AW-1:0]     cur_addr_i,
  input  logic [AW-1:0]     reload_addr_i,
  input  logic [AW-1:0]     offset_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        mode_i,
  input  logic              reload_idx_i,
  input  logic [AREA_W-1:0] area_i,
  input  logic              ovf_en_i,
  output logic [AW-1:0]     next_addr_o,
  output logic              ovf_irq_o
);

  logic [AW-1:0] base_w;
  logic [AW-1:0] addend_w;
  logic          sub_w;
  logic [AW-1:0] updated_w;
  logic          wrap_w;
  logic          upd_fire_w;
  logic [AW-1:0] addr_q;
  logic          ovf_q;

  assign base_w     = reload_i ? reload_addr_i : cur_addr_i;
  assign upd_fire_w = reload_i ? reload_idx_i : beat_i;

  dma_addr_step #(.AW(AW)) u_step (
    .mode_i   (mode_i),
    .size_i   (size_i),
    .offset_i (offset_i),
    .addend_o (addend_w),
    .sub_o    (sub_w)
  );

  dma_addr_wrap #(.AW(AW), .AREA_W(AREA_W)) u_wrap (
    .base_i   (base_w),
    .addend_i (addend_w),
    .sub_i    (sub_w),
    .area_i   (area_i),
    .result_o (updated_w),
    .wrap_o   (wrap_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      ovf_q <= upd_fire_w & wrap_w & ovf_en_i;
      if (reload_i)    addr_q <= reload_idx_i ? updated_w : reload_addr_i;
      else if (beat_i) addr_q <= updated_w;
    end
  end

  assign next_addr_o = addr_q;
  assign ovf_irq_o   = ovf_q;

  // R2: fixed mode returns the current address and never signals overflow
  a_r2_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i && !reload_i && mode_i == 2'b00) |=> (next_addr_o == $past(cur_addr_i) && !ovf_irq_o));

  // R6: plain reload loads the reload address and raises nothing
  a_r6_plain_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && !reload_idx_i) |=> (next_addr_o == $past(reload_addr_i) && !ovf_irq_o));

  // R8: bits above the window are untouched by a beat
  a_r8_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i && !reload_i && area_i != '0) |=>
      ((next_addr_o >> $past(area_i)) == ($past(cur_addr_i) >> $past(area_i))));

  // R9: no request while the enable is clear
  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_en_i |=> !ovf_irq_o);

  // R10: idle cycle holds the address and produces no pulse
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_i && !reload_i) |=> ($stable(next_addr_o) && !ovf_irq_o));

endmodule

// File: tb/dma_addr_upd_bench.sv
module dma_addr_upd_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        beat_i = 1'b0, reload_i = 1'b0, reload_idx_i = 1'b0, ovf_en_i = 1'b0;
  logic [31:0] cur_addr_i = '0, reload_addr_i = '0, offset_i = '0;
  logic [1:0]  size_i = '0, mode_i = '0;
  logic [3:0]  area_i = '0;
  logic [31:0] next_addr_o;
  logic        ovf_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  dma_addr_upd u_dma_addr_upd (
    .clk(clk), .rst_n(rst_n), .beat_i(beat_i), .reload_i(reload_i),
    .cur_addr_i(cur_addr_i), .reload_addr_i(reload_addr_i), .offset_i(offset_i),
    .size_i(size_i), .mode_i(mode_i), .reload_idx_i(reload_idx_i),
    .area_i(area_i), .ovf_en_i(ovf_en_i),
    .next_addr_o(next_addr_o), .ovf_irq_o(ovf_irq_o)
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Arithmetic model: window treated as a modulus on integers.
  function automatic void model(input logic [31:0] base, input logic [1:0] mode,
                                input logic [1:0] size, input logic [3:0] area,
                                input logic [31:0] off,
                                output logic [31:0] res, output logic w);
    longint unsigned modv, lowb, hi, amt, nl, step;
    step = (size == 0) ? 1 : (size == 1) ? 2 : (size == 2) ? 4 : 0;
    amt  = (mode == 0) ? 0 : (mode == 1) ? longint'(off) : step;
    w = 1'b0;
    if (area == 0) begin
      modv = 64'h1_0000_0000;
      nl = (mode == 3) ? (longint'(base) + modv - amt) % modv : (longint'(base) + amt) % modv;
      res = nl[31:0];
    end else begin
      modv = 64'd1 << area;
      lowb = longint'(base) % modv;
      hi   = longint'(base) - lowb;
      amt  = amt % modv;
      if (mode == 3) begin
        if (lowb < amt) begin w = 1'b1; nl = lowb + modv - amt; end
        else nl = lowb - amt;
      end else begin
        nl = lowb + amt;
        if (nl >= modv) begin w = 1'b1; nl = nl - modv; end
      end
      res = 32'(hi + nl);
    end
  endfunction

  // Drive one cycle at the falling edge, sample after the next rising edge.
  task automatic cycle(input logic b, input logic r, input logic ri);
    beat_i = b; reload_i = r; reload_idx_i = ri;
    @(negedge clk);
    beat_i = 0; reload_i = 0; reload_idx_i = 0;
  endtask

  task automatic idle_check(input logic [31:0] held);
    cycle(0, 0, 0);
    check32("R10", next_addr_o, held);
    check32("R10", {31'd0, ovf_irq_o}, 32'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_a;
    logic        exp_w;
    logic [31:0] bases [4];
    logic [3:0]  areas [7];
    string       tag;
    bases[0] = 32'h1234_5670; bases[1] = 32'hA5A5_00FF;
    bases[2] = 32'hFFFF_FFFE; bases[3] = 32'h0000_0001;
    areas[0] = 0; areas[1] = 1; areas[2] = 2; areas[3] = 3;
    areas[4] = 4; areas[5] = 8; areas[6] = 15;

    @(negedge clk);
    check32("R1", next_addr_o, 32'd0);
    check32("R1", {31'd0, ovf_irq_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check32("R1", next_addr_o, 32'd0);
    check32("R1", {31'd0, ovf_irq_o}, 32'd0);

    // Beat sweep over mode x size x area x base x enable
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int a = 0; a < 7; a++)
          for (int b = 0; b < 4; b++)
            for (int e = 0; e < 2; e++) begin
              mode_i = 2'(m); size_i = 2'(s); area_i = areas[a];
              cur_addr_i = bases[b]; ovf_en_i = e[0];
              offset_i = (b[0]) ? 32'h0000_0013 : 32'h8000_0FFC;
              model(cur_addr_i, mode_i, size_i, area_i, offset_i, exp_a, exp_w);
              cycle(1, 0, 0);
              if (area_i != 0) tag = "R8";
              else if (m == 0) tag = "R2";
              else if (m == 1) tag = "R5";
              else if (m == 2) tag = "R3";
              else tag = "R4";
              check32(tag, next_addr_o, exp_a);
              check32("R9", {31'd0, ovf_irq_o}, {31'd0, exp_w & e[0]});
              if (b == 0) idle_check(exp_a);
            end

    // Reload sweep with a simultaneous beat
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 7; a++)
        for (int i = 0; i < 2; i++) begin
          mode_i = 2'(m); size_i = 2'b10; area_i = areas[a]; ovf_en_i = 1'b1;
          cur_addr_i = 32'h5555_5555; reload_addr_i = 32'h0C0F_FFFF;
          offset_i = 32'h0000_0101;
          model(reload_addr_i, mode_i, size_i, area_i, offset_i, exp_a, exp_w);
          cycle(1, 1, i[0]);
          if (i == 0) begin
            check32("R6", next_addr_o, reload_addr_i);
            check32("R6", {31'd0, ovf_irq_o}, 32'd0);
          end else begin
            check32("R7", next_addr_o, exp_a);
            check32("R9", {31'd0, ovf_irq_o}, {31'd0, exp_w});
          end
          idle_check(next_addr_o);
        end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule